// File: doc/BRIEF.md
# I2C Burst Receive Engine

This block clocks a counted run of bytes in from an I2C target once addressing is done. It then queues those bytes for the host. A one-cycle command supplies a byte count and a flag. The flag asks for the final byte of the burst to be answered with a NAK instead of an ACK. While the burst runs, the block drives SCL, samples SDA on each rising SCL edge and assembles each byte most significant bit first. It drives the acknowledge bit in the ninth clock pulse and pushes every finished byte into a receive FIFO. When the last byte's acknowledge slot closes, a sticky done flag rises. START, STOP and address transmission belong to a neighbouring block.

A long read is split into FIFO-sized bursts. Every burst but the final one is issued with the NAK flag clear, so all of its bytes are acknowledged. Only the closing burst sets the flag, so the target sees a NAK after the very last byte of the transfer.

The FIFO drains through a valid/ready stream port. A byte is taken on any cycle where `rx_valid` and `rx_ready` are both high. While `rx_valid` is high and `rx_ready` is low, the head byte and `rx_valid` hold steady. `rx_ready` may be raised with no data waiting: `rx_data` then reads zero and nothing moves.

Top module: `i2c_rx_burst`

## Requirements
- R1: After reset, `busy` and `read_done` are low, `scl_out` is high, `sda_pull` is low and `rx_valid` is low.
- R2: A command accepted while idle with count N (1 to DEPTH) raises `busy` on the next cycle. It produces exactly 9×N rising SCL edges. At the close of the last acknowledge slot it drops `busy` and sets `read_done`, which stays set until the next accepted command.
- R3: SDA is sampled on each rising SCL edge. Each byte is built most significant bit first, and bytes leave the FIFO in the order they arrived.
- R4: `sda_pull` (1 = drive SDA low) is high during the ninth SCL pulse of every byte, which is an ACK. The exception is the final byte of a burst whose NAK flag was set: there it stays low, releasing SDA for a NAK. `sda_pull` is low during all eight data pulses.
- R5: A command with count 0 sets `read_done` on the next cycle, never raises `busy` and produces no SCL edge.
- R6: A count above DEPTH is treated as DEPTH.
- R7: `cmd_valid` while `busy` is high is ignored: the running burst keeps its own count and NAK flag.
- R8: `rx_valid` is high whenever the FIFO holds a byte, and `rx_data` then shows the oldest byte. A byte is removed only on a cycle with `rx_valid` and `rx_ready` both high. Under back-pressure the head byte holds steady.
- R9: With the FIFO empty, `rx_data` reads zero and asserting `rx_ready` changes nothing.
- R10: A byte that finishes while the FIFO already holds DEPTH bytes is discarded, and the stored bytes are untouched.
- R11: Accepting a command with a non-zero count clears `read_done` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle burst command strobe |
| cmd_count | input | CNT_W (7) | Bytes to receive, 0 to 127, clamped to DEPTH |
| cmd_nak_last | input | 1 | NAK the final byte of this burst |
| busy | output | 1 | Burst in progress |
| read_done | output | 1 | Sticky: last burst finished |
| scl_out | output | 1 | SCL level driven by the block |
| sda_in | input | 1 | Sampled SDA level |
| sda_pull | output | 1 | 1 = pull SDA low (ACK) |
| rx_valid | output | 1 | FIFO holds a byte |
| rx_ready | input | 1 | Consumer takes the head byte |
| rx_data | output | 8 | Head byte, zero when empty |

## Verification
Random bursts of 1 to 64 bytes with random data and a random NAK flag are drained under random back-pressure. These runs separate correct bit order, byte order and acknowledge placement from off-by-one slips in the bit or byte counters. Directed cases cover the edges. A single byte with a lone set bit exposes a reversed shifter. A zero count must leave SCL quiet. An oversize count must stop at DEPTH bytes. A stray command in mid-burst must not alter the run. Two bursts without draining overfill the FIFO and show that the overflow is dropped, not written over.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int BYTE_W  = 8;
  localparam int ACK_IDX = 8;  // bit slot carrying the acknowledge
  typedef logic [BYTE_W-1:0] byte_t;
  typedef enum logic {ST_IDLE, ST_RUN} rx_state_e;
endpackage

// File: rtl/i2c_rx_sclgen.sv
module i2c_rx_sclgen #(
  parameter int HALF_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic scl,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int HW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;

  logic [HW-1:0] half_cnt;
  logic          phase_hi;
  logic          at_end;

  assign at_end = (half_cnt == HW'(HALF_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      half_cnt <= '0;
      phase_hi <= 1'b0;
    end else if (at_end) begin
      half_cnt <= '0;
      phase_hi <= ~phase_hi;
    end else begin
      half_cnt <= half_cnt + 1'b1;
    end
  end

  assign scl      = run ? phase_hi : 1'b1;
  assign rise_evt = run & ~phase_hi & at_end;
  assign fall_evt = run &  phase_hi & at_end;
endmodule

// File: rtl/i2c_rx_shifter.sv
module i2c_rx_shifter
  import i2c_rx_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  run,
  input  logic  rise_evt,
  input  logic  fall_evt,
  input  logic  sda_in,
  output byte_t rx_byte,
  output logic  byte_ready,
  output logic  slot_end,
  output logic  in_ack_slot
);
  localparam int BCW = $clog2(ACK_IDX + 1);

  logic [BCW-1:0] bit_idx;
  byte_t          shreg;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      bit_idx <= '0;
    end else if (fall_evt) begin
      bit_idx <= (bit_idx == BCW'(ACK_IDX)) ? '0 : bit_idx + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
    end else if (rise_evt && (bit_idx < BCW'(ACK_IDX))) begin
      shreg <= {shreg[BYTE_W-2:0], sda_in};
    end
  end

  assign rx_byte     = shreg;
  assign byte_ready  = fall_evt && (bit_idx == BCW'(ACK_IDX - 1));
  assign slot_end    = fall_evt && (bit_idx == BCW'(ACK_IDX));
  assign in_ack_slot = run && (bit_idx == BCW'(ACK_IDX));
endmodule

// File: rtl/i2c_rx_fifo.sv
module i2c_rx_fifo
  import i2c_rx_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  byte_t         push_data,
  input  logic          pop,
  output byte_t         head,
  output logic          not_empty,
  output logic [LW-1:0] level
);
  byte_t         mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;

  assign not_empty = (level != '0);
  assign do_push   = push && (level != LW'(DEPTH));
  assign do_pop    = pop && not_empty;
  assign head      = not_empty ? mem[rptr] : '0;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/i2c_rx_burst.sv
module i2c_rx_burst
  import i2c_rx_pkg::*;
#(
  parameter  int DEPTH       = 64,
  parameter  int HALF_CYCLES = 4,
  localparam int CNT_W       = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             cmd_nak_last,
  output logic             busy,
  output logic             read_done,
  output logic             scl_out,
  input  logic             sda_in,
  output logic             sda_pull,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic [7:0]       rx_data
);
  localparam int LW = $clog2(DEPTH + 1);

  rx_state_e        state;
  logic [CNT_W-1:0] remaining;
  logic             nak_r;
  logic             done_r;
  logic             run, accept;
  logic [CNT_W-1:0] eff_count;
  logic             rise_evt, fall_evt;
  logic             byte_ready, slot_end, in_ack_slot;
  byte_t            rx_byte;
  logic [LW-1:0]    fifo_level;

  assign run       = (state == ST_RUN);
  assign accept    = cmd_valid && !run;
  assign eff_count = (cmd_count > CNT_W'(DEPTH)) ? CNT_W'(DEPTH) : cmd_count;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      remaining <= '0;
      nak_r     <= 1'b0;
      done_r    <= 1'b0;
    end else if (accept) begin
      nak_r     <= cmd_nak_last;
      remaining <= eff_count;
      if (eff_count == '0) begin
        done_r <= 1'b1;
      end else begin
        done_r <= 1'b0;
        state  <= ST_RUN;
      end
    end else if (run && slot_end) begin
      remaining <= remaining - 1'b1;
      if (remaining == CNT_W'(1)) begin
        state  <= ST_IDLE;
        done_r <= 1'b1;
      end
    end
  end

  i2c_rx_sclgen #(.HALF_CYCLES(HALF_CYCLES)) u_scl (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .scl      (scl_out),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  i2c_rx_shifter u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .rise_evt    (rise_evt),
    .fall_evt    (fall_evt),
    .sda_in      (sda_in),
    .rx_byte     (rx_byte),
    .byte_ready  (byte_ready),
    .slot_end    (slot_end),
    .in_ack_slot (in_ack_slot)
  );

  i2c_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (byte_ready),
    .push_data (rx_byte),
    .pop       (rx_ready),
    .head      (rx_data),
    .not_empty (rx_valid),
    .level     (fifo_level)
  );

  assign sda_pull  = in_ack_slot && !((remaining == CNT_W'(1)) && nak_r);
  assign busy      = run;
  assign read_done = done_r;
endmodule

// File: rtl/i2c_rx_burst_chk.sv
module i2c_rx_burst_chk #(
  parameter  int DEPTH = 64,
  parameter  int CNT_W = 7,
  localparam int LW    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [CNT_W-1:0] cmd_count,
  input logic             busy,
  input logic             read_done,
  input logic             scl_out,
  input logic             sda_pull,
  input logic             rx_valid,
  input logic             rx_ready,
  input logic [7:0]       rx_data,
  input logic [LW-1:0]    fifo_level
);
  a_r1_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl_out && !sda_pull));

  a_r2_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    read_done |-> !busy);

  a_r4_release_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull) |-> (!scl_out || !busy));

  a_r5_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_count == '0) |=> (read_done && !busy));

  a_r11_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy && cmd_count != '0) |=> (busy && !read_done));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  a_r9_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> (rx_data == 8'h00));

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));
endmodule

bind i2c_rx_burst i2c_rx_burst_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid),
  .cmd_count  (cmd_count),
  .busy       (busy),
  .read_done  (read_done),
  .scl_out    (scl_out),
  .sda_pull   (sda_pull),
  .rx_valid   (rx_valid),
  .rx_ready   (rx_ready),
  .rx_data    (rx_data),
  .fifo_level (fifo_level)
);

// File: tb/i2c_rx_burst_test.sv
module i2c_rx_burst_test;
  localparam int DEPTH = 64;
  localparam int CNT_W = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cmd_valid = 1'b0;
  logic [CNT_W-1:0] cmd_count = '0;
  logic             cmd_nak_last = 1'b0;
  logic             busy, read_done, scl_out, sda_pull, rx_valid;
  logic             sda_in = 1'b1;
  logic             rx_ready = 1'b0;
  logic [7:0]       rx_data;

  int total = 0;
  int fails = 0;

  logic [7:0] tx_mem [128];
  logic       ack_log [128];
  logic [7:0] exp_q [$];
  int  idx = 0, bidx = 0, rise_cnt = 0, pull_err = 0;
  bit  prev_scl = 1'b0;

  always #2 clk = ~clk;

  i2c_rx_burst #(.DEPTH(DEPTH), .HALF_CYCLES(4)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_count(cmd_count),
    .cmd_nak_last(cmd_nak_last), .busy(busy), .read_done(read_done),
    .scl_out(scl_out), .sda_in(sda_in), .sda_pull(sda_pull),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data)
  );

  // Target model: presents data bits while SCL is low, logs the acknowledge.
  always @(negedge clk) begin
    if (!busy) begin
      idx = 0;
      bidx = 0;
      prev_scl = 1'b0;
    end else begin
      if (prev_scl && !scl_out) begin
        idx = idx + 1;
        if (idx == 9) begin
          idx = 0;
          bidx = bidx + 1;
        end
      end
      if (!prev_scl && scl_out) begin
        rise_cnt = rise_cnt + 1;
        if (idx == 8) ack_log[bidx] = sda_pull;
        else if (sda_pull) pull_err = pull_err + 1;
      end
      prev_scl = scl_out;
    end
    sda_in = (idx < 8) ? tx_mem[bidx][7-idx] : 1'b1;
  end

  function automatic bit exp_ack(input int i, input int n, input bit nak);
    return !((i == n - 1) && nak);
  endfunction

  function automatic int clamp_count(input int c);
    return (c > DEPTH) ? DEPTH : c;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_burst(input int cnt, input bit nak, input int first, input bit stray);
    int eff, r0, e0, n;
    bit ok;
    eff = clamp_count(cnt);
    for (int i = 0; i < 128; i++) tx_mem[i] = 8'($urandom);
    if (first >= 0) tx_mem[0] = 8'(first);
    r0 = rise_cnt;
    e0 = pull_err;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_count = CNT_W'(cnt); cmd_nak_last = nak;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (eff == 0) begin
      chk(read_done && !busy, "R5 zero count done", int'(read_done), 1);
      repeat (20) @(negedge clk);
      chk(rise_cnt == r0, "R5 zero count no SCL", rise_cnt - r0, 0);
      return;
    end
    chk(busy && !read_done, "R11 start clears done", int'(read_done), 0);
    if (stray) begin
      repeat (100) @(negedge clk);
      cmd_valid = 1'b1; cmd_count = 7'd40; cmd_nak_last = ~nak;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    n = 0;
    while (!read_done && n < 7000) begin
      @(negedge clk);
      n++;
    end
    chk(read_done && !busy, "R2 done and idle", int'(read_done), 1);
    chk(rise_cnt - r0 == 9 * eff, (cnt > DEPTH) ? "R6 clamped pulses" :
        (stray ? "R7 stray ignored pulses" : "R2 pulse count"), rise_cnt - r0, 9 * eff);
    ok = 1'b1;
    for (int i = 0; i < eff; i++) if (ack_log[i] !== exp_ack(i, eff, nak)) ok = 1'b0;
    chk(ok, "R4 ack pattern", int'(ok), 1);
    chk(pull_err == e0, "R4 no pull on data bits", pull_err - e0, 0);
    for (int i = 0; i < eff; i++)
      if (exp_q.size() < DEPTH) exp_q.push_back(tx_mem[i]);
  endtask

  task automatic drain(input bit rand_ready);
    int n, derr, herr;
    bit pv, pr;
    logic [7:0] pd, e;
    n = 0; derr = 0; herr = 0; pv = 1'b0; pr = 1'b0; pd = '0;
    while (exp_q.size() > 0 && n < 3000) begin
      @(negedge clk);
      n++;
      if (pv && !pr && !(rx_valid && rx_data == pd)) herr++;
      rx_ready = rand_ready ? 1'($urandom) : 1'b1;
      if (rx_ready && rx_valid) begin
        e = exp_q.pop_front();
        if (rx_data !== e) begin
          derr++;
          $display("FAIL R3 byte actual=%0h expected=%0h", rx_data, e);
        end
      end
      pv = rx_valid; pr = rx_ready; pd = rx_data;
    end
    @(negedge clk);
    rx_ready = 1'b0;
    chk(derr == 0, "R3 data order and bit order", derr, 0);
    chk(herr == 0, "R8 hold under back-pressure", herr, 0);
    chk(exp_q.size() == 0, "R8 all bytes delivered", exp_q.size(), 0);
    chk(!rx_valid && rx_data == 8'h00, "R8 empty after drain", int'(rx_valid), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    bit ok;
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 128; i++) tx_mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !read_done && scl_out && !sda_pull && !rx_valid,
        "R1 reset state", int'(busy), 0);

    // R9: empty reads return zero and disturb nothing
    rx_ready = 1'b1;
    ok = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (rx_valid || rx_data != 8'h00) ok = 1'b0;
    end
    rx_ready = 1'b0;
    chk(ok, "R9 empty read is zero", int'(rx_data), 0);
    run_burst(1, 1'b1, 8'h5A, 1'b0);
    drain(1'b0);

    // R3: lone set bits expose a reversed shifter
    run_burst(1, 1'b0, 8'h80, 1'b0);
    drain(1'b0);
    run_burst(2, 1'b1, 8'h01, 1'b0);
    drain(1'b1);

    // R5: zero count
    run_burst(0, 1'b1, -1, 1'b0);

    // R6: oversize count clamps
    run_burst(100, 1'b1, -1, 1'b0);
    drain(1'b1);

    // R7: stray command mid-burst
    run_burst(5, 1'b1, -1, 1'b1);
    drain(1'b0);

    // R10: overfill without draining
    run_burst(60, 1'b0, -1, 1'b0);
    run_burst(10, 1'b1, -1, 1'b0);
    chk(exp_q.size() == DEPTH, "R10 queue capped", exp_q.size(), DEPTH);
    drain(1'b1);

    // Random bursts, one full-depth burst included
    run_burst(64, 1'b0, -1, 1'b0);
    drain(1'b1);
    for (int k = 0; k < 10; k++) begin
      run_burst(1 + int'($urandom % 64), 1'($urandom), -1, 1'b0);
      drain(1'b1);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule